// File: doc/BRIEF.md
# Signed character word shifter

This block moves the characters of a twelve-character word by a count of 1 to 9 character places. It is started with a one-cycle strobe that presents the word, a two-bit mode and the count together. The mode picks the direction and whether the sign character takes part in the shift. The leftmost character holds the sign. In the two sign-excluding modes only the eleven digit characters move, and the sign stays where it is. Vacated places always fill with zero characters.

The result is registered. A done flag pulses in the cycle after the strobe, and the result stays on the output until the next strobe. A count outside 1 to 9 does not shift the word. The word is returned unchanged and an illegal-count flag is raised.

A two-state controller sequences the block. It has two states. ST_IDLE is the state after reset and the state when no result is fresh. ST_DONE is the state in which the done flag is high. There are three transitions. IDLE goes to DONE on a start strobe. DONE stays in DONE on a start strobe. DONE goes back to IDLE when no strobe is present.

Top module: `char_word_shifter`

## Requirements
- R1: After reset, `word_out` is all zeros, and `done` and `bad_count` are low.
- R2: `done` is high in exactly the cycle after each cycle in which `start` is high, and low in every other cycle. `word_out` and `bad_count` take their new values in that same cycle.
- R3: The mode encoding is as follows: bit 1 = 1 selects a left shift, and bit 0 = 1 excludes the sign. Characters are CHAR_W bits wide. Character 11 (the top bits) is the sign, and character 0 (the low bits) is the least significant digit. Mode 00 with a legal count n moves all twelve characters right by n. The n low characters are lost, and n zero characters enter at the top.
- R4: Mode 10 with a legal count n moves all twelve characters left by n. The n top characters are lost, and zero characters fill the n low places.
- R5: Mode 01 with a legal count n moves characters 10..0 right by n. Zeros enter the n highest digit places, and character 11 keeps its input value.
- R6: Mode 11 with a legal count n moves characters 10..0 left by n. Zeros fill the n lowest places, and character 11 keeps its input value.
- R7: A count from 1 to 9 is legal and sets `bad_count` low. A count of 0, or any count from 10 to 15, makes `word_out` equal `word_in` and sets `bad_count` high, in every mode.
- R8: While `start` is low, changes on `word_in`, `mode` and `count` have no effect on `word_out` or `bad_count`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle strobe; captures the operands |
| mode | input | 2 | Bit 1: left; bit 0: exclude sign |
| count | input | 4 | Shift distance in characters |
| word_in | input | 72 | Twelve characters of CHAR_W = 6 bits |
| word_out | output | 72 | Registered shifted word |
| done | output | 1 | High in the cycle after `start` |
| bad_count | output | 1 | High when the last count was illegal |

## Verification
A wrong controller state shows at the ports within one cycle. A lost or extra transition makes `done` miss the cycle after a strobe or stay high for a second cycle. A wrong character mux or sign path shows in the first result after that strobe, as a misplaced character, a nonzero fill or a changed sign. The bench sweeps every mode and every 4-bit count over several word patterns. It checks each result in the done cycle. It then checks one cycle later that the result holds while the inputs change.

// File: rtl/sc_shift_pkg.sv
package sc_shift_pkg;

    typedef enum logic [1:0] {
        SH_RIGHT_ALL = 2'b00,
        SH_RIGHT_DIG = 2'b01,
        SH_LEFT_ALL  = 2'b10,
        SH_LEFT_DIG  = 2'b11
    } shift_mode_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_DONE = 1'b1
    } ctrl_state_e;

endpackage

// File: rtl/sc_count_check.sv
module sc_count_check #(
    parameter int CNT_W     = 4,
    parameter int MAX_SHIFT = 9
) (
    input  logic [CNT_W-1:0] count,
    output logic             legal
);
    always_comb begin
        legal = (int'(count) >= 1) && (int'(count) <= MAX_SHIFT);
    end
endmodule

// File: rtl/sc_char_barrel.sv
module sc_char_barrel #(
    parameter int CHAR_W = 6,
    parameter int LEN    = 12,
    parameter int CNT_W  = 4
) (
    input  logic [LEN*CHAR_W-1:0] din,
    input  logic                  dir_left,
    input  logic [CNT_W-1:0]      amt,
    output logic [LEN*CHAR_W-1:0] dout
);
    for (genvar i = 0; i < LEN; i++) begin : g_char
        logic [CHAR_W-1:0] pick;
        always_comb begin
            pick = '0;
            for (int k = 0; k < LEN; k++) begin
                if (dir_left ? (k + int'(amt) == i) : (k == i + int'(amt))) begin
                    pick = din[k*CHAR_W +: CHAR_W];
                end
            end
        end
        assign dout[i*CHAR_W +: CHAR_W] = pick;
    end
endmodule

// File: rtl/sc_ctrl_fsm.sv
module sc_ctrl_fsm
    import sc_shift_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic done
);
    ctrl_state_e state_q;
    ctrl_state_e state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_d = ST_DONE;
            ST_DONE: state_d = start ? ST_DONE : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        done = (state_q == ST_DONE);
    end

    AST_DONE_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> done); // R2
    AST_DONE_ONLY_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> !done); // R2
endmodule

// File: rtl/char_word_shifter.sv
module char_word_shifter
    import sc_shift_pkg::*;
#(
    parameter int CHAR_W    = 6,
    parameter int NUM_CHARS = 12,
    parameter int CNT_W     = 4,
    parameter int MAX_SHIFT = 9
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        start,
    input  logic [1:0]                  mode,
    input  logic [CNT_W-1:0]            count,
    input  logic [NUM_CHARS*CHAR_W-1:0] word_in,
    output logic [NUM_CHARS*CHAR_W-1:0] word_out,
    output logic                        done,
    output logic                        bad_count
);
    localparam int WORD_W = NUM_CHARS * CHAR_W;
    localparam int DIG_N  = NUM_CHARS - 1;
    localparam int DIG_W  = DIG_N * CHAR_W;

    shift_mode_e       mode_e;
    logic              legal;
    logic [WORD_W-1:0] full_shift;
    logic [DIG_W-1:0]  dig_shift;
    logic [WORD_W-1:0] result;

    assign mode_e = shift_mode_e'(mode);

    sc_count_check #(.CNT_W(CNT_W), .MAX_SHIFT(MAX_SHIFT)) u_chk (
        .count (count),
        .legal (legal)
    );

    sc_char_barrel #(.CHAR_W(CHAR_W), .LEN(NUM_CHARS), .CNT_W(CNT_W)) u_full (
        .din      (word_in),
        .dir_left (mode[1]),
        .amt      (count),
        .dout     (full_shift)
    );

    sc_char_barrel #(.CHAR_W(CHAR_W), .LEN(DIG_N), .CNT_W(CNT_W)) u_dig (
        .din      (word_in[DIG_W-1:0]),
        .dir_left (mode[1]),
        .amt      (count),
        .dout     (dig_shift)
    );

    sc_ctrl_fsm u_fsm (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .done  (done)
    );

    always_comb begin
        result = word_in;
        if (legal) begin
            unique case (mode_e)
                SH_RIGHT_ALL, SH_LEFT_ALL: result = full_shift;
                SH_RIGHT_DIG, SH_LEFT_DIG:
                    result = {word_in[WORD_W-1 -: CHAR_W], dig_shift};
                default: result = word_in;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_out  <= '0;
            bad_count <= 1'b0;
        end else if (start) begin
            word_out  <= result;
            bad_count <= !legal;
        end
    end

    AST_BAD_KEEPS_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !legal) |=> (bad_count && word_out == $past(word_in))); // R7
    AST_SIGN_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        (start && legal && mode[0]) |=>
        (word_out[WORD_W-1 -: CHAR_W] == $past(word_in[WORD_W-1 -: CHAR_W]))); // R5
    AST_RIGHT_ZERO_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        (start && legal && mode == 2'b00) |=> (word_out[WORD_W-1 -: CHAR_W] == '0)); // R3
    AST_LEFT_ZERO_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (start && legal && mode[1]) |=> (word_out[CHAR_W-1:0] == '0)); // R4
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> ($stable(word_out) && $stable(bad_count))); // R8
endmodule

// File: tb/sim_char_word_shifter.sv
module sim_char_word_shifter;
    localparam int CW = 6;
    localparam int NC = 12;
    localparam int WW = CW * NC;
    localparam int DW = CW * (NC - 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [1:0]    mode = 2'b00;
    logic [3:0]    count = 4'd0;
    logic [WW-1:0] word_in = '0;
    logic [WW-1:0] word_out;
    logic          done;
    logic          bad_count;

    int tests = 0;
    int fails = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    char_word_shifter u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .count(count),
        .word_in(word_in), .word_out(word_out), .done(done), .bad_count(bad_count)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            fails = fails + 1;
            $display("FAIL watchdog: act=hung exp=finished");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    function automatic logic [WW-1:0] model(logic [WW-1:0] w, logic [1:0] m, int n);
        logic [WW-1:0] mask_all;
        logic [DW-1:0] dig;
        if (n < 1 || n > 9) return w;
        mask_all = '1;
        if (!m[0]) begin
            if (m[1]) return (w << (n * CW)) & mask_all;
            else      return w >> (n * CW);
        end
        dig = w[DW-1:0];
        if (m[1]) dig = dig << (n * CW);
        else      dig = dig >> (n * CW);
        return {w[WW-1 -: CW], dig};
    endfunction

    task automatic check_vec(string tag, logic [WW-1:0] act, logic [WW-1:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic check_bit(string tag, logic act, logic exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: act=%0b exp=%0b", tag, act, exp);
        end
    endtask

    task automatic run_op(logic [1:0] m, int n, logic [WW-1:0] w);
        logic [WW-1:0] exp_w;
        logic          exp_bad;
        string         tag;
        exp_w   = model(w, m, n);
        exp_bad = (n < 1 || n > 9);
        if (exp_bad)       tag = "R7";
        else if (m == 2'b00) tag = "R3";
        else if (m == 2'b10) tag = "R4";
        else if (m == 2'b01) tag = "R5";
        else                 tag = "R6";
        @(negedge clk);
        mode = m; count = 4'(n); word_in = w; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check_vec(tag, word_out, exp_w);
        check_bit("R7 flag", bad_count, exp_bad);
        check_bit("R2 done high", done, 1'b1);
        mode = ~m; count = 4'(n + 3); word_in = ~w;
        @(negedge clk);
        check_bit("R2 done low", done, 1'b0);
        check_vec("R8 hold word", word_out, exp_w);
        check_bit("R8 hold flag", bad_count, exp_bad);
    endtask

    initial begin
        logic [WW-1:0] pat [4];
        logic [WW-1:0] lf;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_vec("R1 word", word_out, '0);
        check_bit("R1 done", done, 1'b0);
        check_bit("R1 bad", bad_count, 1'b0);

        for (int c = 0; c < NC; c++) pat[0][c*CW +: CW] = 6'(c + 1);
        pat[1] = '1;
        lf = 72'h9A_3C5E_71F0_2B84_D6E1;
        pat[2] = lf;
        pat[3] = {6'h2D, {(NC-1){6'h15}}};

        for (int p = 0; p < 4; p++)
            for (int m = 0; m < 4; m++)
                for (int n = 0; n < 16; n++)
                    run_op(2'(m), n, pat[p]);

        for (int r = 0; r < 40; r++) begin
            lf = {lf[WW-2:0], lf[WW-1] ^ lf[WW-7] ^ lf[3] ^ lf[0]};
            run_op(2'(r), (r % 9) + 1, lf);
        end

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule